// File: doc/BRIEF.md
# Single-channel DMA transfer engine

The block holds the register set of one DMA channel (source address, destination address, 24-bit transfer count, control word) and a global operation register. When software requests a run of N units, the engine moves them one at a time over a valid/ready memory port. For each unit it reads from the source and writes to the destination. It then steps each address according to that address's own mode, decrements the count and writes the new values back into the channel registers.

A unit is 1, 2, 4, 8 or 32 bytes wide, chosen by a coded control field. Units of up to four bytes take one read beat and one write beat. Wider units are split into four-byte beats, and each read beat is followed at once by its write beat. When the count runs out, the transfer-end flag is set. The interrupt output is high exactly while both the transfer-end flag and the interrupt-enable flag are set, and software can write either flag. A start address that does not suit the unit, or an illegal address mode, sets an error flag and no data moves. While a run is in progress, register writes are ignored.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `busy` and `mem_valid` are 0.
- R2: The register word on `reg_addr` is decoded as follows: 0 is source, 1 is destination, 2 is count (24 bits, upper bits read 0), 3 is control (16 bits) and 4 is global (3 bits). Every written value reads back unchanged. `reg_rdata` follows `reg_addr` in the same cycle.
- R3: Control bits [6:4] select the unit size. Code 0 gives 8 bytes, 1 gives 1, 2 gives 2, 3 gives 4, 4 gives 32, and 5 to 7 give 1. A 1- or 2-byte unit is one beat on the low data lanes with `mem_len` 0 or 1. Any other size uses `mem_len` 2, in beats of four bytes at ascending offsets +0, +4 and so on within the unit.
- R4: Control bits [13:12] set the source address mode and bits [15:14] the destination mode. Code 0 keeps the address fixed, 1 increments it by the unit size after each unit, and 2 decrements it by the unit size.
- R5: A run request is acted on only when the engine is idle, control bit 0 (enable) is 1, control bit 1 (transfer end) is 0 and global bits [2:0] equal 3'b001. In any other case it is ignored: no beats are issued and no register changes.
- R6: A run of N units executes min(N, remaining) units. N = 0 means run to the end of the count. A count of 0 stands for 2^24 remaining units.
- R7: After every unit, the stepped source address, the stepped destination address and the decremented count are written back to their registers.
- R8: When the count reaches 0, control bit 1 (transfer end) is set.
- R9: `irq` is 1 exactly while control bit 2 (interrupt enable) and control bit 1 are both 1. A software write that clears either bit lowers `irq`, and a write that sets both bits raises it.
- R10: A run request that passes R5 while either address mode is 3 sets control bit 3 (address error). It issues no beats and leaves the addresses and the count unchanged.
- R11: A run request that passes R5 while the source or destination address is not a multiple of the unit size also sets control bit 3, and again no data moves.
- R12: `mem_valid` is high only while busy. Its address, direction and write data stay stable until `mem_ready`. Each accepted read beat is followed in the next cycle by its write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe (ignored while busy) |
| reg_addr | input | 3 | Register word select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| run_req | input | 1 | One-cycle request to run units |
| run_units | input | 24 | Units to run, 0 means to the end of the count |
| busy | output | 1 | A run is in progress |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat direction, 1 is write |
| mem_addr | output | 32 | Byte address of the beat |
| mem_len | output | 2 | Beat width, 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes |
| mem_wdata | output | 32 | Write beat data, low lanes first |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ready` on a read |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The clock edge that samples an accepted `run_req` raises `busy` from the next cycle. A rejected request, or one with an error, leaves `busy` low, and the error flag becomes visible one cycle after that edge. Each write beat is issued in the cycle after its read beat is accepted. The addresses and the count change in the cycle after the last write beat of a unit, together with the transfer-end flag and therefore `irq`. For that reason the bench compares every write beat against a scoreboard entry at the falling edge before the accepting rising edge. It reads the registers back only after `busy` has been seen low at a falling edge, and it checks `irq` at the falling edge after each control write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   localparam int CTRL_W    = 16;
   localparam int CTRL_EN   = 0;
   localparam int CTRL_TE   = 1;
   localparam int CTRL_IE   = 2;
   localparam int CTRL_ERR  = 3;
   localparam int SIZE_LSB  = 4;
   localparam int SMODE_LSB = 12;
   localparam int DMODE_LSB = 14;
   localparam int MAX_BEATS = 8;
   localparam logic [2:0] GOP_RUN = 3'b001;

   localparam logic [2:0] RI_SRC  = 3'd0;
   localparam logic [2:0] RI_DST  = 3'd1;
   localparam logic [2:0] RI_CNT  = 3'd2;
   localparam logic [2:0] RI_CTRL = 3'd3;
   localparam logic [2:0] RI_GOP  = 3'd4;

   typedef enum logic [1:0] {
      AM_FIXED = 2'd0,
      AM_INC   = 2'd1,
      AM_DEC   = 2'd2,
      AM_BAD   = 2'd3
   } addr_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_STEP
   } xfer_st_e;

   function automatic logic [5:0] unit_bytes(input logic [2:0] code);
      case (code)
         3'd0:    unit_bytes = 6'd8;
         3'd2:    unit_bytes = 6'd2;
         3'd3:    unit_bytes = 6'd4;
         3'd4:    unit_bytes = 6'd32;
         default: unit_bytes = 6'd1;
      endcase
   endfunction

   function automatic logic [3:0] unit_beats(input logic [2:0] code);
      logic [5:0] b;
      b = unit_bytes(code);
      unit_beats = (b > 6'd4) ? b[5:2] : 4'd1;
   endfunction

   function automatic logic [1:0] beat_len(input logic [2:0] code);
      case (unit_bytes(code))
         6'd1:    beat_len = 2'd0;
         6'd2:    beat_len = 2'd1;
         default: beat_len = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int RA_W   = 3,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [RA_W-1:0]   sw_addr,
   input  logic [DW-1:0]     sw_wdata,
   input  logic              lock,
   input  logic              hw_step,
   input  logic [ADDR_W-1:0] hw_src,
   input  logic [ADDR_W-1:0] hw_dst,
   input  logic [CNT_W-1:0]  hw_cnt,
   input  logic              hw_set_te,
   input  logic              hw_set_err,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [2:0]        gop_q,
   output logic [DW-1:0]     rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
         gop_q  <= '0;
      end else begin
         if (sw_we && !lock) begin
            case (sw_addr)
               RA_W'(RI_SRC):  src_q  <= sw_wdata[ADDR_W-1:0];
               RA_W'(RI_DST):  dst_q  <= sw_wdata[ADDR_W-1:0];
               RA_W'(RI_CNT):  cnt_q  <= sw_wdata[CNT_W-1:0];
               RA_W'(RI_CTRL): ctrl_q <= sw_wdata[CTRL_W-1:0];
               RA_W'(RI_GOP):  gop_q  <= sw_wdata[2:0];
               default: ;
            endcase
         end
         if (hw_step) begin
            src_q <= hw_src;
            dst_q <= hw_dst;
            cnt_q <= hw_cnt;
         end
         if (hw_set_te)  ctrl_q[CTRL_TE]  <= 1'b1;
         if (hw_set_err) ctrl_q[CTRL_ERR] <= 1'b1;
      end
   end

   always_comb begin
      case (sw_addr)
         RA_W'(RI_SRC):  rdata = DW'(src_q);
         RA_W'(RI_DST):  rdata = DW'(dst_q);
         RA_W'(RI_CNT):  rdata = DW'(cnt_q);
         RA_W'(RI_CTRL): rdata = DW'(ctrl_q);
         RA_W'(RI_GOP):  rdata = DW'(gop_q);
         default:        rdata = '0;
      endcase
   end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        mode,
   input  logic [5:0]        nbytes,
   output logic [ADDR_W-1:0] nxt,
   output logic              bad_mode,
   output logic              misaligned
);

   logic [ADDR_W-1:0] stride;

   assign stride = ADDR_W'(nbytes);

   always_comb begin
      case (addr_mode_e'(mode))
         AM_INC:  nxt = addr + stride;
         AM_DEC:  nxt = addr - stride;
         default: nxt = addr;
      endcase
   end

   assign bad_mode   = (addr_mode_e'(mode) == AM_BAD);
   assign misaligned = |(addr & (stride - ADDR_W'(1)));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_req,
   input  logic [CNT_W-1:0]  run_units,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [2:0]        gop,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              cfg_err,
   input  logic              mem_ready,
   input  logic [DW-1:0]     mem_rdata,
   output logic              busy,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [1:0]        mem_len,
   output logic              hw_step,
   output logic [CNT_W-1:0]  hw_cnt,
   output logic              hw_set_te,
   output logic              hw_set_err
);

   localparam int BEAT_W = $clog2(MAX_BEATS);

   xfer_st_e          st;
   logic [BEAT_W-1:0] beat;
   logic [CNT_W:0]    left;
   logic [DW-1:0]     hold;

   logic [2:0]        size_code;
   logic [3:0]        nbeats;
   logic              last_beat;
   logic              runnable;
   logic              start;
   logic [CNT_W:0]    remaining;
   logic [CNT_W:0]    asked;
   logic [CNT_W:0]    grant;
   logic [ADDR_W-1:0] offs;

   assign size_code = ctrl[SIZE_LSB +: 3];
   assign nbeats    = unit_beats(size_code);
   assign last_beat = (beat == BEAT_W'(nbeats - 4'd1));
   assign runnable  = ctrl[CTRL_EN] & ~ctrl[CTRL_TE] & (gop == GOP_RUN);
   assign start     = (st == ST_IDLE) & run_req & runnable;

   assign remaining = (cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt};
   assign asked     = {1'b0, run_units};
   assign grant     = ((run_units == '0) || (asked > remaining)) ? remaining : asked;

   assign hw_set_err = start & cfg_err;
   assign hw_step    = (st == ST_STEP);
   assign hw_cnt     = cnt - CNT_W'(1);
   assign hw_set_te  = hw_step && (cnt == CNT_W'(1));

   assign offs      = ADDR_W'({beat, 2'b00});
   assign busy      = (st != ST_IDLE);
   assign mem_valid = (st == ST_RD) || (st == ST_WR);
   assign mem_we    = (st == ST_WR);
   assign mem_addr  = ((st == ST_WR) ? dst : src) + offs;
   assign mem_wdata = hold;
   assign mem_len   = beat_len(size_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         beat <= '0;
         left <= '0;
         hold <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start && !cfg_err) begin
                  left <= grant;
                  beat <= '0;
                  st   <= ST_RD;
               end
            end
            ST_RD: begin
               if (mem_ready) begin
                  hold <= mem_rdata;
                  st   <= ST_WR;
               end
            end
            ST_WR: begin
               if (mem_ready) begin
                  if (last_beat) begin
                     beat <= '0;
                     st   <= ST_STEP;
                  end else begin
                     beat <= beat + BEAT_W'(1);
                     st   <= ST_RD;
                  end
               end
            end
            default: begin
               left <= left - (CNT_W+1)'(1);
               st   <= (left == (CNT_W+1)'(1)) ? ST_IDLE : ST_RD;
            end
         endcase
      end
   end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int RA_W   = 3,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic              run_req,
   input  logic [CNT_W-1:0]  run_units,
   output logic              busy,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_len,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_ready,
   input  logic [DW-1:0]     mem_rdata,
   output logic              irq
);

   localparam int NPTR = 2;

   if (DW != 32) begin : g_bad_dw
      $error("dma_chan_engine: beats are four bytes, DW must be 32");
   end
   if (ADDR_W < 8 || ADDR_W > DW) begin : g_bad_aw
      $error("dma_chan_engine: ADDR_W must lie in 8..DW");
   end
   if (CNT_W < 2 || CNT_W > DW) begin : g_bad_cw
      $error("dma_chan_engine: CNT_W must lie in 2..DW");
   end
   if (RA_W < 3) begin : g_bad_ra
      $error("dma_chan_engine: RA_W must be at least 3");
   end

   logic [ADDR_W-1:0] src_q, dst_q;
   logic [CNT_W-1:0]  cnt_q, hw_cnt;
   logic [CTRL_W-1:0] ctrl_q;
   logic [2:0]        gop_q;
   logic              hw_step, hw_set_te, hw_set_err;

   logic [ADDR_W-1:0] ptr_cur [NPTR];
   logic [ADDR_W-1:0] ptr_nxt [NPTR];
   logic [1:0]        ptr_mode [NPTR];
   logic [NPTR-1:0]   ptr_bad, ptr_mis;
   logic [5:0]        nbytes;
   logic              cfg_err;

   assign nbytes      = unit_bytes(ctrl_q[SIZE_LSB +: 3]);
   assign ptr_cur[0]  = src_q;
   assign ptr_cur[1]  = dst_q;
   assign ptr_mode[0] = ctrl_q[SMODE_LSB +: 2];
   assign ptr_mode[1] = ctrl_q[DMODE_LSB +: 2];

   for (genvar p = 0; p < NPTR; p++) begin : g_ptr
      dma_addr_step #(.ADDR_W(ADDR_W)) step_i (
         .addr       (ptr_cur[p]),
         .mode       (ptr_mode[p]),
         .nbytes     (nbytes),
         .nxt        (ptr_nxt[p]),
         .bad_mode   (ptr_bad[p]),
         .misaligned (ptr_mis[p])
      );
   end

   assign cfg_err = (|ptr_bad) | (|ptr_mis);

   dma_chan_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .RA_W   (RA_W),
      .DW     (DW)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we      (reg_we),
      .sw_addr    (reg_addr),
      .sw_wdata   (reg_wdata),
      .lock       (busy),
      .hw_step    (hw_step),
      .hw_src     (ptr_nxt[0]),
      .hw_dst     (ptr_nxt[1]),
      .hw_cnt     (hw_cnt),
      .hw_set_te  (hw_set_te),
      .hw_set_err (hw_set_err),
      .src_q      (src_q),
      .dst_q      (dst_q),
      .cnt_q      (cnt_q),
      .ctrl_q     (ctrl_q),
      .gop_q      (gop_q),
      .rdata      (reg_rdata)
   );

   dma_xfer_seq #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DW     (DW)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_req    (run_req),
      .run_units  (run_units),
      .ctrl       (ctrl_q),
      .gop        (gop_q),
      .src        (src_q),
      .dst        (dst_q),
      .cnt        (cnt_q),
      .cfg_err    (cfg_err),
      .mem_ready  (mem_ready),
      .mem_rdata  (mem_rdata),
      .busy       (busy),
      .mem_valid  (mem_valid),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_len    (mem_len),
      .hw_step    (hw_step),
      .hw_cnt     (hw_cnt),
      .hw_set_te  (hw_set_te),
      .hw_set_err (hw_set_err)
   );

   assign irq = ctrl_q[CTRL_IE] & ctrl_q[CTRL_TE];

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int DW     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic              busy,
   input logic              mem_valid,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_len,
   input logic [DW-1:0]     mem_wdata,
   input logic              mem_ready,
   input logic              irq
);

   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R12
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && !mem_we |=> mem_valid && mem_we);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_valid);

   // R3
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_len == 2'd2 |-> mem_addr[1:0] == 2'b00);

   // R3
   half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_len == 2'd1 |-> mem_addr[0] == 1'b0);

   // R9
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(reg_we));

   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(reg_we) || $past(busy));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W), .DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .busy      (busy),
   .mem_valid (mem_valid),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_len   (mem_len),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .irq       (irq)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      logic [1:0]  len;
   } wr_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        run_req = 1'b0;
   logic [23:0] run_units = '0;
   logic        busy, mem_valid, mem_we, irq;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_len;
   logic        mem_ready = 1'b0;

   int n_total = 0;
   int n_fail  = 0;
   int beat_cnt = 0;
   logic [4:0] lfsr = 5'h15;
   logic [7:0] mem [0:1023];
   wr_item_t exp_q [$];

   always #10 clk = ~clk;

   dma_chan_engine dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_req(run_req),
      .run_units(run_units), .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
   );

   function automatic logic [7:0] pat(input logic [31:0] a);
      return 8'((a[9:0] * 13) + 7);
   endfunction

   function automatic logic [31:0] lane_mask(input logic [1:0] len);
      return (len == 2'd0) ? 32'h0000_00FF : (len == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
   endfunction

   always_comb begin
      mem_rdata = {mem[10'(mem_addr + 3)], mem[10'(mem_addr + 2)],
                   mem[10'(mem_addr + 1)], mem[10'(mem_addr)]};
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: handshake resolves at the next rising edge, judged here at the falling edge
   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         beat_cnt++;
         if (mem_we) begin
            if (exp_q.size() == 0) begin
               n_total++;
               n_fail++;
               $display("FAIL R12 unexpected write actual=%h expected=none", mem_addr);
            end else begin
               wr_item_t e;
               e = exp_q.pop_front();
               chk("R4 write address", mem_addr, e.addr);
               chk("R3 write length", 32'(mem_len), 32'(e.len));
               chk("R3 write data", mem_wdata & lane_mask(mem_len), e.data);
            end
            for (int k = 0; k < 4; k++)
               if (k == 0 || (k < 2 && mem_len != 2'd0) || mem_len == 2'd2)
                  mem[10'(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
         end
      end
      lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      mem_ready = (lfsr[1:0] != 2'b00);
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   function automatic int bytes_of(input logic [2:0] code);
      case (code)
         3'd0: return 8;
         3'd2: return 2;
         3'd3: return 4;
         3'd4: return 32;
         default: return 1;
      endcase
   endfunction

   function automatic int step_of(input logic [1:0] m, input int sz);
      return (m == 2'd1) ? sz : (m == 2'd2) ? -sz : 0;
   endfunction

   // driver: program, push expected write beats, pulse the request, wait for idle
   task automatic run_case(input logic [31:0] src, input logic [31:0] dst,
                           input logic [23:0] cnt, input logic [15:0] ctrl,
                           input logic [23:0] n, input int units);
      int sz, nb, ss, ds;
      logic [1:0] ln;
      sz = bytes_of(ctrl[6:4]);
      nb = (sz > 4) ? sz / 4 : 1;
      ln = (sz == 1) ? 2'd0 : (sz == 2) ? 2'd1 : 2'd2;
      ss = step_of(ctrl[13:12], sz);
      ds = step_of(ctrl[15:14], sz);
      wr(3'd0, src);
      wr(3'd1, dst);
      wr(3'd2, 32'(cnt));
      wr(3'd3, 32'(ctrl));
      for (int u = 0; u < units; u++) begin
         for (int b = 0; b < nb; b++) begin
            wr_item_t e;
            logic [31:0] sa;
            sa = src + 32'(u * ss) + 32'(4 * b);
            e.addr = dst + 32'(u * ds) + 32'(4 * b);
            e.len  = ln;
            e.data = {pat(sa + 3), pat(sa + 2), pat(sa + 1), pat(sa)} & lane_mask(ln);
            exp_q.push_back(e);
         end
      end
      run_req = 1'b1; run_units = n;
      @(negedge clk);
      run_req = 1'b0;
      while (busy) @(negedge clk);
      chk("R6 beats left unmatched", 32'(exp_q.size()), 32'd0);
      exp_q.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      int b0;
      for (int a = 0; a < 1024; a++) mem[a] = pat(32'(a));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 mem_valid", 32'(mem_valid), 32'd0);
      chk_reg("R1 src", 3'd0, 32'd0);
      chk_reg("R1 ctrl", 3'd3, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_reg("R1 count", 3'd2, 32'd0);

      // R2 readback
      wr(3'd4, 32'hFFFF_FFF9);
      chk_reg("R2 global", 3'd4, 32'd1);
      wr(3'd2, 32'hAB12_3456);
      chk_reg("R2 count width", 3'd2, 32'h0012_3456);
      wr(3'd1, 32'hDEAD_BEEF);
      chk_reg("R2 dst", 3'd1, 32'hDEAD_BEEF);

      // 4-byte units, both incrementing, run to end with interrupt enabled
      run_case(32'h000, 32'h200, 24'd4, 16'h5035, 24'd0, 4);
      chk_reg("R7 src inc", 3'd0, 32'h010);
      chk_reg("R7 dst inc", 3'd1, 32'h210);
      chk_reg("R7 count", 3'd2, 32'd0);
      chk_reg("R8 te set", 3'd3, 32'h5037);
      chk("R9 irq raised", 32'(irq), 32'd1);
      wr(3'd3, 32'h5033);
      chk("R9 irq drops on IE clear", 32'(irq), 32'd0);
      wr(3'd3, 32'h5037);
      chk("R9 irq on software set", 32'(irq), 32'd1);
      wr(3'd3, 32'h5035);
      chk("R9 irq drops on TE clear", 32'(irq), 32'd0);

      // 1-byte, source inc, destination fixed, partial run then rest
      run_case(32'h040, 32'h280, 24'd5, 16'h1011, 24'd2, 2);
      chk_reg("R6 partial count", 3'd2, 32'd3);
      chk_reg("R4 dst fixed", 3'd1, 32'h280);
      chk_reg("R8 te clear mid run", 3'd3, 32'h1011);
      begin
         logic [31:0] s;
         rd(3'd0, s);
         chk("R7 src after partial", s, 32'h042);
         // continue from written-back state with N above remaining
         for (int u = 0; u < 3; u++) begin
            wr_item_t e;
            e.addr = 32'h280; e.len = 2'd0; e.data = 32'(pat(32'h042 + 32'(u)));
            exp_q.push_back(e);
         end
         run_req = 1'b1; run_units = 24'd10;
         @(negedge clk);
         run_req = 1'b0;
         while (busy) @(negedge clk);
         chk("R6 capped run beats", 32'(exp_q.size()), 32'd0);
         exp_q.delete();
      end
      chk_reg("R6 capped src", 3'd0, 32'h045);
      chk_reg("R8 te after cap", 3'd3, 32'h1013);
      chk("R9 no irq without IE", 32'(irq), 32'd0);

      // 2-byte, source decrement, destination increment
      run_case(32'h0A0, 32'h300, 24'd3, 16'h6021, 24'd0, 3);
      chk_reg("R4 src dec", 3'd0, 32'h09A);
      chk_reg("R4 dst inc", 3'd1, 32'h306);

      // 8-byte units (code 0)
      run_case(32'h100, 32'h320, 24'd2, 16'h5001, 24'd0, 2);
      chk_reg("R3 8-byte src", 3'd0, 32'h110);
      chk_reg("R3 8-byte dst", 3'd1, 32'h330);

      // 32-byte unit, destination decrement
      run_case(32'h140, 32'h380, 24'd1, 16'h9041, 24'd0, 1);
      chk_reg("R3 32-byte src", 3'd0, 32'h160);
      chk_reg("R4 32-byte dst dec", 3'd1, 32'h360);

      // code 5 is one byte, both fixed
      run_case(32'h0C3, 32'h3F0, 24'd2, 16'h0051, 24'd0, 2);
      chk_reg("R4 src fixed", 3'd0, 32'h0C3);
      chk_reg("R3 code5 count", 3'd2, 32'd0);

      // count 0 stands for 2^24
      run_case(32'h0D0, 32'h3A0, 24'd0, 16'h5011, 24'd3, 3);
      chk_reg("R6 zero count wraps", 3'd2, 32'h00FF_FFFD);
      chk_reg("R8 no te on big count", 3'd3, 32'h5011);

      // illegal source mode
      b0 = beat_cnt;
      run_case(32'h000, 32'h200, 24'd4, 16'h7031, 24'd0, 0);
      chk_reg("R10 error bit", 3'd3, 32'h7039);
      chk_reg("R10 count kept", 3'd2, 32'd4);
      chk_reg("R10 src kept", 3'd0, 32'h000);
      chk("R10 no beats", 32'(beat_cnt - b0), 32'd0);

      // misaligned source for 4-byte unit
      b0 = beat_cnt;
      run_case(32'h102, 32'h200, 24'd4, 16'h5031, 24'd0, 0);
      chk_reg("R11 error bit", 3'd3, 32'h5039);
      chk_reg("R11 count kept", 3'd2, 32'd4);
      chk("R11 no beats", 32'(beat_cnt - b0), 32'd0);

      // global register not 3'b001
      wr(3'd4, 32'h3);
      b0 = beat_cnt;
      run_case(32'h000, 32'h200, 24'd4, 16'h5031, 24'd0, 0);
      chk_reg("R5 global off ctrl", 3'd3, 32'h5031);
      chk_reg("R5 global off count", 3'd2, 32'd4);
      chk("R5 global off beats", 32'(beat_cnt - b0), 32'd0);
      wr(3'd4, 32'h1);

      // transfer end already set
      b0 = beat_cnt;
      run_case(32'h000, 32'h200, 24'd4, 16'h5033, 24'd0, 0);
      chk_reg("R5 te set count", 3'd2, 32'd4);
      chk("R5 te set beats", 32'(beat_cnt - b0), 32'd0);

      // enable off
      b0 = beat_cnt;
      run_case(32'h000, 32'h200, 24'd4, 16'h5030, 24'd0, 0);
      chk_reg("R5 disabled count", 3'd2, 32'd4);
      chk("R5 disabled beats", 32'(beat_cnt - b0), 32'd0);

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule